// File: doc/BRIEF.md
# Pin I/O Controller with Sticky Edge and Level Interrupts

This block is a register-mapped general-purpose pin controller for up to 32 pins. Each pin takes one bit in every control word. Software sets the input enable, output enable, output data, output inversion and pull-up for a pin. It can also write drive-strength and alternate-function words, which the block only stores. Each pin's level is resolved from three sources, in a fixed order: an external driver, then the block's own output driver, then the pull-up. The block samples this level every clock and keeps the result in a read-only value word.

Each pin has four interrupt sources: rising edge, falling edge, level high and level low. Each source has its own enable word and its own sticky pending word. Software clears a pending bit by writing a one to it. A pin's interrupt line is the OR of its enabled pending bits. External level and driven-qualifier inputs pass through a synchronizer before they are used. A per-pin contention flag reports when a pin is driven from outside while its output is enabled.

Top module: `pin_io_ctrl`

## Requirements
- R1: `pin_out[i]` equals `pin_oe[i] & (data[i] ^ invert[i])`, and `pin_oe` mirrors the output-enable word. The words sit at offsets 0x08 (output enable), 0x0C (data) and 0x40 (invert). The outputs follow a write in the cycle after the write edge.
- R2: The level of a pin is resolved in a fixed order. If `ext_drive[i]` is set, the level is `ext_level[i]`. Otherwise, if output enable is set, it is the driven value from R1. Otherwise it is the pull-up bit (offset 0x10).
- R3: The value word at offset 0x00 reads `input_enable & resolved level` per pin; input enable is at offset 0x04. Writes to offset 0x00 have no effect.
- R4: High-pending (offset 0x2C) is set, and stays set, in every cycle the sampled value is 1. Low-pending (offset 0x34) is set, and stays set, in every cycle the sampled value is 0.
- R5: Rise-pending (offset 0x1C) is set when the sampled value goes from 0 to 1. Fall-pending (offset 0x24) is set when it goes from 1 to 0.
- R6: A write to a pending word clears exactly the bits written as 1. If a bit is set and cleared in the same cycle, the set wins.
- R7: `irq[i]` is the OR of the four pending bits of pin i, each ANDed with its enable. The enables are at 0x18 (rise), 0x20 (fall), 0x28 (high) and 0x30 (low).
- R8: Reset clears every control word, every pending word, the stored sampled value and the synchronizer stages.
- R9: Only word-aligned offsets that are defined respond. A read of any other offset returns zero, and a write to it changes nothing.
- R10: `clash[i]` is set while the synchronized `ext_drive[i]` and the output enable are both set.
- R11: The external inputs pass through SYNC_STAGES flops (default 2). A change on `ext_level`/`ext_drive` reaches the sampled value and pending words on the third clock edge. Read data appears on the edge that takes `bus_rd`.
- R12: The drive-strength (0x14), alternate-enable (0x38) and alternate-select (0x3C) words read back what was written and have no effect on any pin output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Byte offset of access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ext_level | input | N_PINS | Level applied by an outside driver |
| ext_drive | input | N_PINS | Outside driver active per pin |
| pin_out | output | N_PINS | Driven output value |
| pin_oe | output | N_PINS | Output enable per pin |
| irq | output | N_PINS | Per-pin interrupt line |
| clash | output | N_PINS | Outside and inside drive both active |

## Verification
A register write takes effect on the pin outputs and the interrupt lines at the edge that accepts it. Read data is registered, so the bench samples it at the falling edge after the read strobe. A change on the external inputs reaches the interrupt lines only on the third edge. The bench therefore checks `irq` at the falling edges after the first, second and third edges, and expects the change only at the last. Checks that depend on the sampled value wait at least one edge after the write or input change that causes it. Every value is sampled at a falling edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int ADDR_W = 7;
   localparam int DATA_W = 32;
   localparam int NUM_EV = 4;

   // event kinds; index order fixes the enable/pending offset pairs
   typedef enum logic [1:0] {EV_RISE = 2'd0, EV_FALL = 2'd1, EV_HIGH = 2'd2, EV_LOW = 2'd3} ev_kind_e;

   localparam logic [ADDR_W-1:0] OFS_VALUE   = 7'h00;
   localparam logic [ADDR_W-1:0] OFS_IN_EN   = 7'h04;
   localparam logic [ADDR_W-1:0] OFS_OUT_EN  = 7'h08;
   localparam logic [ADDR_W-1:0] OFS_DATA    = 7'h0C;
   localparam logic [ADDR_W-1:0] OFS_PULL    = 7'h10;
   localparam logic [ADDR_W-1:0] OFS_DRIVE   = 7'h14;
   localparam logic [ADDR_W-1:0] OFS_EV_BASE = 7'h18;
   localparam logic [ADDR_W-1:0] OFS_ALT_EN  = 7'h38;
   localparam logic [ADDR_W-1:0] OFS_ALT_SEL = 7'h3C;
   localparam logic [ADDR_W-1:0] OFS_INVERT  = 7'h40;

   function automatic logic [ADDR_W-1:0] ev_en_ofs(input int e);
      return ADDR_W'(OFS_EV_BASE + 8 * e);
   endfunction

   function automatic logic [ADDR_W-1:0] ev_pend_ofs(input int e);
      return ADDR_W'(OFS_EV_BASE + 8 * e + 4);
   endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int N_PINS = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          rd_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   output logic [DATA_W-1:0]             rdata,
   input  logic [N_PINS-1:0]             value_q,
   input  logic [NUM_EV-1:0][N_PINS-1:0] pend,
   output logic [N_PINS-1:0]             in_en,
   output logic [N_PINS-1:0]             out_en,
   output logic [N_PINS-1:0]             data,
   output logic [N_PINS-1:0]             pull,
   output logic [N_PINS-1:0]             invert,
   output logic [NUM_EV-1:0][N_PINS-1:0] ev_en,
   output logic [NUM_EV-1:0][N_PINS-1:0] ev_clr
);
   localparam int PW = N_PINS;

   logic [PW-1:0]     drive_q, alt_en_q, alt_sel_q;
   logic [PW-1:0]     wbits;
   logic [DATA_W-1:0] rd_mux;
   logic              rd_hit;

   assign wbits = wdata[PW-1:0];

   // plain read/write words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_en     <= '0;
         out_en    <= '0;
         data      <= '0;
         pull      <= '0;
         invert    <= '0;
         drive_q   <= '0;
         alt_en_q  <= '0;
         alt_sel_q <= '0;
         ev_en     <= '0;
      end else if (wr_en) begin
         case (addr)
            OFS_IN_EN:   in_en     <= wbits;
            OFS_OUT_EN:  out_en    <= wbits;
            OFS_DATA:    data      <= wbits;
            OFS_PULL:    pull      <= wbits;
            OFS_INVERT:  invert    <= wbits;
            OFS_DRIVE:   drive_q   <= wbits;
            OFS_ALT_EN:  alt_en_q  <= wbits;
            OFS_ALT_SEL: alt_sel_q <= wbits;
            default: ;
         endcase
         for (int e = 0; e < NUM_EV; e++) begin
            if (addr == ev_en_ofs(e)) ev_en[e] <= wbits;
         end
      end
   end

   // write-one-to-clear strobes, one word per event kind
   for (genvar e = 0; e < NUM_EV; e++) begin : g_clr
      assign ev_clr[e] = (wr_en && addr == ev_pend_ofs(e)) ? wbits : '0;
   end

   always_comb begin
      rd_hit = 1'b1;
      rd_mux = '0;
      case (addr)
         OFS_VALUE:   rd_mux = DATA_W'(value_q);
         OFS_IN_EN:   rd_mux = DATA_W'(in_en);
         OFS_OUT_EN:  rd_mux = DATA_W'(out_en);
         OFS_DATA:    rd_mux = DATA_W'(data);
         OFS_PULL:    rd_mux = DATA_W'(pull);
         OFS_INVERT:  rd_mux = DATA_W'(invert);
         OFS_DRIVE:   rd_mux = DATA_W'(drive_q);
         OFS_ALT_EN:  rd_mux = DATA_W'(alt_en_q);
         OFS_ALT_SEL: rd_mux = DATA_W'(alt_sel_q);
         default:     rd_hit = 1'b0;
      endcase
      for (int e = 0; e < NUM_EV; e++) begin
         if (addr == ev_en_ofs(e)) begin
            rd_hit = 1'b1;
            rd_mux = DATA_W'(ev_en[e]);
         end
         if (addr == ev_pend_ofs(e)) begin
            rd_hit = 1'b1;
            rd_mux = DATA_W'(pend[e]);
         end
      end
      if (!rd_hit) rd_mux = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_hit) |=> (rdata == '0));                                   // R9
endmodule

// File: rtl/pio_pin_core.sv
module pio_pin_core
   import pio_pkg::*;
#(
   parameter int N_PINS = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_PINS-1:0]             ext_lvl_s,
   input  logic [N_PINS-1:0]             ext_drv_s,
   input  logic [N_PINS-1:0]             in_en,
   input  logic [N_PINS-1:0]             out_en,
   input  logic [N_PINS-1:0]             data,
   input  logic [N_PINS-1:0]             pull,
   input  logic [N_PINS-1:0]             invert,
   input  logic [NUM_EV-1:0][N_PINS-1:0] ev_en,
   input  logic [NUM_EV-1:0][N_PINS-1:0] ev_clr,
   output logic [N_PINS-1:0]             value_q,
   output logic [NUM_EV-1:0][N_PINS-1:0] pend,
   output logic [N_PINS-1:0]             pin_out,
   output logic [N_PINS-1:0]             pin_oe,
   output logic [N_PINS-1:0]             irq,
   output logic [N_PINS-1:0]             clash
);
   logic [N_PINS-1:0]             level, smp;
   logic [NUM_EV-1:0][N_PINS-1:0] ev_set;

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      assign pin_out[i] = out_en[i] & (data[i] ^ invert[i]);
      // outside driver first, then own driver, then pull-up
      assign level[i]   = ext_drv_s[i] ? ext_lvl_s[i] :
                          out_en[i]    ? pin_out[i]   : pull[i];
      assign smp[i]     = in_en[i] & level[i];
      assign clash[i]   = ext_drv_s[i] & out_en[i];

      assign ev_set[EV_RISE][i] =  smp[i] & ~value_q[i];
      assign ev_set[EV_FALL][i] = ~smp[i] &  value_q[i];
      assign ev_set[EV_HIGH][i] =  smp[i];
      assign ev_set[EV_LOW][i]  = ~smp[i];

      always_comb begin
         irq[i] = 1'b0;
         for (int e = 0; e < NUM_EV; e++) irq[i] = irq[i] | (pend[e][i] & ev_en[e][i]);
      end

      AST_RISE_WITH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend[EV_RISE][i]) |-> pend[EV_HIGH][i]);                          // R5
      AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_en[EV_RISE][i] == 1'b0 && ev_en[EV_FALL][i] == 1'b0 &&
          ev_en[EV_HIGH][i] == 1'b0 && ev_en[EV_LOW][i] == 1'b0) |-> !irq[i]);  // R7
      AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
         pin_out[i] |-> pin_oe[i]);                                              // R1
      AST_CLASH_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
         clash[i] |-> ext_drv_s[i]);                                             // R10
      AST_VALUE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !in_en[i] |=> !value_q[i]);                                             // R3

      for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
         AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[e][i] && !ev_clr[e][i]) |=> pend[e][i]);                       // R4
      end
   end

   assign pin_oe = out_en;

   // set has priority over a same-cycle write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
         pend    <= '0;
      end else begin
         value_q <= smp;
         for (int e = 0; e < NUM_EV; e++) pend[e] <= (pend[e] & ~ev_clr[e]) | ev_set[e];
      end
   end
endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl
   import pio_pkg::*;
#(
   parameter int N_PINS      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [N_PINS-1:0]   ext_level,
   input  logic [N_PINS-1:0]   ext_drive,
   output logic [N_PINS-1:0]   pin_out,
   output logic [N_PINS-1:0]   pin_oe,
   output logic [N_PINS-1:0]   irq,
   output logic [N_PINS-1:0]   clash
);
   localparam int SYNC_W = 2 * N_PINS;

   if (N_PINS < 1 || N_PINS > DATA_W) begin : g_bad_pins
      $error("pin_io_ctrl: N_PINS must lie in 1..32");
   end

   logic [SYNC_W-1:0]             sync_q;
   logic [N_PINS-1:0]             ext_lvl_s, ext_drv_s;
   logic [N_PINS-1:0]             in_en, out_en, data, pull, invert, value_q;
   logic [NUM_EV-1:0][N_PINS-1:0] ev_en, ev_clr, pend;

   pio_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ext_drive, ext_level}),
      .q     (sync_q)
   );

   assign ext_lvl_s = sync_q[N_PINS-1:0];
   assign ext_drv_s = sync_q[SYNC_W-1:N_PINS];

   pio_regs #(.N_PINS(N_PINS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .rd_en   (bus_rd),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .rdata   (bus_rdata),
      .value_q (value_q),
      .pend    (pend),
      .in_en   (in_en),
      .out_en  (out_en),
      .data    (data),
      .pull    (pull),
      .invert  (invert),
      .ev_en   (ev_en),
      .ev_clr  (ev_clr)
   );

   pio_pin_core #(.N_PINS(N_PINS)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_lvl_s (ext_lvl_s),
      .ext_drv_s (ext_drv_s),
      .in_en     (in_en),
      .out_en    (out_en),
      .data      (data),
      .pull      (pull),
      .invert    (invert),
      .ev_en     (ev_en),
      .ev_clr    (ev_clr),
      .value_q   (value_q),
      .pend      (pend),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq),
      .clash     (clash)
   );

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && irq == '0));                             // R8
endmodule

// File: tb/pin_io_ctrl_test.sv
`timescale 1ns/1ps
module pin_io_ctrl_test;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] ext_level = '0, ext_drive = '0;
   logic [N-1:0] pin_out, pin_oe, irq, clash;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pin_io_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_level(ext_level), .ext_drive(ext_drive),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .clash(clash)
   );

   // {offset, write data, expected readback}
   localparam logic [70:0] VEC [12] = '{
      {7'h04, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
      {7'h14, 32'h1234_5678, 32'h1234_5678},
      {7'h18, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
      {7'h20, 32'hF0F0_F0F0, 32'hF0F0_F0F0},
      {7'h28, 32'h00FF_00FF, 32'h00FF_00FF},
      {7'h30, 32'hFF00_FF00, 32'hFF00_FF00},
      {7'h38, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
      {7'h3C, 32'h1357_9BDF, 32'h1357_9BDF},
      {7'h40, 32'h8000_0001, 32'h8000_0001},
      {7'h44, 32'hFFFF_FFFF, 32'h0000_0000},
      {7'h05, 32'hFFFF_FFFF, 32'h0000_0000},
      {7'h7C, 32'h0000_0001, 32'h0000_0000}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #1_000_000ns;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=expired expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      // R8 reset state
      idle(3);
      check("R8 pin_out in reset", 32'(pin_out), 32'h0);
      check("R8 irq in reset", 32'(irq | clash | pin_oe), 32'h0);
      rst_n = 1'b1;
      bus_read(7'h04, rd); check("R8 input enable after reset", rd, 32'h0);
      bus_read(7'h00, rd); check("R8 value after reset", rd, 32'h0);

      // table walk: R12 plain words, R9 undefined offsets
      for (int k = 0; k < 12; k++) begin
         bus_write(VEC[k][70:64], VEC[k][63:32]);
         bus_read(VEC[k][70:64], rd);
         check($sformatf("R12/R9 table entry %0d", k), rd, VEC[k][31:0]);
      end
      check("R12 stored words leave pins idle", 32'(pin_out | pin_oe), 32'h0);
      for (int k = 0; k < 9; k++) bus_write(VEC[k][70:64], 32'h0);

      // R1 driven value
      bus_write(7'h08, 32'h0F);
      bus_write(7'h0C, 32'h05);
      bus_write(7'h40, 32'h03);
      check("R1 pin_out", 32'(pin_out), 32'h06);
      check("R1 pin_oe", 32'(pin_oe), 32'h0F);

      // R2 resolution order, R10 contention
      bus_write(7'h10, 32'h30);
      bus_write(7'h04, 32'hFFFF_FFFF);
      @(negedge clk);
      ext_drive = 32'h101; ext_level = 32'h100;
      idle(4);
      bus_read(7'h00, rd); check("R2 resolved value", rd, 32'h136);
      check("R10 clash", 32'(clash), 32'h001);

      // R3 input enable masks, writes to value ignored
      bus_write(7'h04, 32'hFFFF_FFEF);
      bus_read(7'h00, rd); check("R3 masked value", rd, 32'h126);
      bus_write(7'h00, 32'hFFFF_FFFF);
      bus_read(7'h00, rd); check("R3 value write ignored", rd, 32'h126);

      // clear all pending, then R11 timing of a falling edge
      bus_write(7'h1C, 32'hFFFF_FFFF);
      bus_write(7'h24, 32'hFFFF_FFFF);
      bus_write(7'h2C, 32'hFFFF_FFFF);
      bus_write(7'h34, 32'hFFFF_FFFF);
      bus_write(7'h20, 32'h100);
      idle(2);
      check("R7 irq quiet before edge", 32'(irq), 32'h0);
      @(negedge clk);
      ext_level = 32'h0;
      @(negedge clk); check("R11 irq after first edge", 32'(irq), 32'h0);
      @(negedge clk); check("R11 irq after second edge", 32'(irq), 32'h0);
      @(negedge clk); check("R5 R11 fall irq after third edge", 32'(irq), 32'h100);

      // R6 write one to clear
      bus_write(7'h24, 32'h100);
      check("R6 irq cleared", 32'(irq), 32'h0);
      bus_read(7'h24, rd); check("R6 fall pending cleared", rd, 32'h0);

      // R4 level pending re-set wins over clear
      bus_write(7'h2C, 32'hFFFF_FFFF);
      bus_write(7'h34, 32'hFFFF_FFFF);
      bus_read(7'h2C, rd); check("R4 R6 high pending", rd, 32'h026);
      bus_read(7'h34, rd); check("R4 R6 low pending", rd, 32'hFFFF_FFD9);

      // R5 rising edge
      bus_write(7'h18, 32'h100);
      @(negedge clk);
      ext_level = 32'h100;
      idle(3);
      check("R5 rise irq", 32'(irq), 32'h100);
      bus_read(7'h1C, rd); check("R5 rise pending", rd, 32'h100);

      // R7 level enables
      bus_write(7'h28, 32'h2);
      bus_write(7'h30, 32'h1);
      check("R7 irq combine", 32'(irq), 32'h103);

      // R9 misaligned write ignored
      bus_write(7'h09, 32'h0);
      bus_read(7'h08, rd); check("R9 misaligned write ignored", rd, 32'h0F);

      // R8 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      check("R8 outputs in second reset", 32'(pin_out | pin_oe | irq | clash), 32'h0);
      rst_n = 1'b1;
      bus_read(7'h08, rd); check("R8 output enable cleared", rd, 32'h0);
      bus_read(7'h28, rd); check("R8 high enable cleared", rd, 32'h0);
      bus_read(7'h00, rd); check("R8 value cleared", rd, 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule